// File: doc/BRIEF.md
# Two-Channel Converter Input Staging Latch

This block is the digital entry stage of a two-channel 14-bit converter. Sample words arrive on parallel buses and pass through two register stages per channel: a write-strobed holding register, then a clock-strobed output register that feeds the converter core. Each channel's strobes have equal periods but may differ in phase. A clock edge may coincide with its write edge or come before it, which gives a fixed one-edge pipeline from bus to core.

A static mode pin, sampled during reset, picks one of two arrangements. In dual-bus arrangement, the two channels are fully independent and each has its own bus, write strobe and clock. In shared-bus arrangement, channel A's bus carries interleaved words for both channels. Channel A's strobes drive both channels, and everything on channel B's side is unused. The words alternate A, B, A, B from reset. Both output registers load together once a pair is complete, so the two cores always see samples from the same pair.

Top module: `dual_dac_latch`

## Requirements
- R1: Words are WIDTH bits wide (default 14). Any value, including all zeros and all ones, reaches the core output unchanged.
- R2: The level of `mode_dual` while `rst` is high selects the arrangement: 1 is dual-bus and 0 is shared-bus.
- R3: In dual-bus arrangement, a rising `wr_a` captures `data_a` and a rising `clk_a` moves the captured word to `core_a`. With coincident edges, a word present at write edge k is on `core_a` after edge k+1.
- R4: In dual-bus arrangement, channel B behaves the same way on `data_b`, `wr_b`, `clk_b` and `core_b`, independent of channel A. A `clk_b` edge that leads `wr_b` gives the same result as a coincident one.
- R5: In shared-bus arrangement, `data_b`, `wr_b` and `clk_b` have no effect on either output.
- R6: In shared-bus arrangement, the first `wr_a` edge after reset captures its word for channel A, the next captures for channel B, and the two alternate from then on.
- R7: In shared-bus arrangement, `core_a` and `core_b` load on the same `clk_a` edge, once every two edges. Words written at edges 2n and 2n+1 appear after edge 2n+2. Between loads both outputs hold.
- R8: A synchronous active-high `rst` clears both holding registers, both output registers and the interleave phase, so the next word goes to channel A.
- R9: A change of `mode_dual` while `rst` is low has no effect until the next reset.
- R10: Each clock rising edge coincides with or precedes its channel's write rising edge. When it comes after, the gap is at least 2 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous reset, active high, sampled on every strobe |
| mode_dual | input | 1 | Arrangement select, latched during reset (1 = dual-bus) |
| wr_a | input | 1 | Channel A write strobe (shared in shared-bus arrangement) |
| clk_a | input | 1 | Channel A clock (shared in shared-bus arrangement) |
| data_a | input | WIDTH | Channel A bus, or interleaved bus |
| wr_b | input | 1 | Channel B write strobe |
| clk_b | input | 1 | Channel B clock |
| data_b | input | WIDTH | Channel B bus |
| core_a | output | WIDTH | Word held for the A converter core |
| core_b | output | WIDTH | Word held for the B converter core |

## Verification
The assertions take for granted that each channel's write strobe and clock produce the same number of rising edges. They also assume each clock edge coincides with or leads its write edge, and that `rst` stays high across at least one edge of every strobe. The bench derives all four strobes from one 100 MHz source so these assumptions hold. Channel A's write and clock are tied together, and channel B's clock leads its write by 1 ns. Bus data changes only halfway between edges. A monitor measures every clock-after-write gap against the 2 ns limit.

// File: rtl/dual_dac_latch.sv
module dual_dac_latch #(
  parameter int WIDTH = 14
) (
  input  logic             rst,
  input  logic             mode_dual,
  input  logic             wr_a,
  input  logic             clk_a,
  input  logic [WIDTH-1:0] data_a,
  input  logic             wr_b,
  input  logic             clk_b,
  input  logic [WIDTH-1:0] data_b,
  output logic [WIDTH-1:0] core_a,
  output logic [WIDTH-1:0] core_b
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic             mode_w, mode_c;
  logic             wph, cph;
  logic [WIDTH-1:0] hold_a, hold_b_sh, hold_b_du;
  logic [WIDTH-1:0] out_a, out_b_sh, out_b_du;

  // channel A write side: also steers interleaved words in shared-bus mode
  always_ff @(posedge wr_a) begin
    if (rst) begin
      mode_w    <= mode_dual;
      wph       <= 1'b0;
      hold_a    <= ZERO;
      hold_b_sh <= ZERO;
    end else if (mode_w) begin
      hold_a <= data_a;
    end else begin
      if (wph) hold_b_sh <= data_a;
      else     hold_a    <= data_a;
      wph <= ~wph;
    end
  end

  // channel A clock side: loads both cores per completed pair in shared-bus mode
  always_ff @(posedge clk_a) begin
    if (rst) begin
      mode_c   <= mode_dual;
      cph      <= 1'b0;
      out_a    <= ZERO;
      out_b_sh <= ZERO;
    end else if (mode_c) begin
      out_a <= hold_a;
    end else begin
      if (!cph) begin
        out_a    <= hold_a;
        out_b_sh <= hold_b_sh;
      end
      cph <= ~cph;
    end
  end

  always_ff @(posedge wr_b) begin
    if (rst) hold_b_du <= ZERO;
    else     hold_b_du <= data_b;
  end

  always_ff @(posedge clk_b) begin
    if (rst) out_b_du <= ZERO;
    else     out_b_du <= hold_b_du;
  end

  assign core_a = out_a;
  assign core_b = mode_c ? out_b_du : out_b_sh;

endmodule

module dual_dac_latch_chk #(
  parameter int WIDTH = 14
) (
  input logic             rst,
  input logic             wr_a,
  input logic             clk_a,
  input logic [WIDTH-1:0] data_a,
  input logic             mode_w,
  input logic             mode_c,
  input logic             wph,
  input logic             cph,
  input logic [WIDTH-1:0] hold_a,
  input logic [WIDTH-1:0] core_a,
  input logic [WIDTH-1:0] core_b
);

  p_dual_pipe_r3: assert property (@(posedge clk_a) disable iff (rst)
    (mode_c && !$past(rst)) |-> core_a == $past(hold_a));

  p_steer_a_first_r6: assert property (@(posedge wr_a) disable iff (rst)
    (!mode_w && wph && !$past(rst)) |-> hold_a == $past(data_a));

  p_pair_hold_r7: assert property (@(posedge clk_a) disable iff (rst)
    (!mode_c && !cph && !$past(rst)) |-> ($stable(core_a) && $stable(core_b)));

  p_reset_clear_r8: assert property (@(posedge clk_a) disable iff (rst)
    $past(rst) |-> (core_a == '0 && !cph));

  p_phase_start_r8: assert property (@(posedge wr_a) disable iff (rst)
    $past(rst) |-> !wph);

endmodule

bind dual_dac_latch dual_dac_latch_chk #(.WIDTH(WIDTH)) chk_i (
  .rst(rst), .wr_a(wr_a), .clk_a(clk_a), .data_a(data_a),
  .mode_w(mode_w), .mode_c(mode_c), .wph(wph), .cph(cph),
  .hold_a(hold_a), .core_a(core_a), .core_b(core_b)
);

// File: tb/dual_dac_latch_tb.sv
`timescale 1ns/1ps
module dual_dac_latch_tb_top;
  localparam int W = 14;

  logic         rst = 1'b1, mode_dual = 1'b1;
  logic         clk = 1'b0, clk_b = 1'b0, wr_b = 1'b0;
  logic [W-1:0] data_a = '0, data_b = '0;
  logic [W-1:0] core_a, core_b;
  wire          wr_a = clk;

  int compared = 0, mismatched = 0;
  int ord_viol = 0;

  logic         m_mode = 1'b1, m_ph = 1'b0;
  logic [W-1:0] m_ha = '0, m_hb = '0, m_ca = '0, m_cb = '0;

  dual_dac_latch #(.WIDTH(W)) dut_i (
    .rst(rst), .mode_dual(mode_dual), .wr_a(wr_a), .clk_a(clk),
    .data_a(data_a), .wr_b(wr_b), .clk_b(clk_b), .data_b(data_b),
    .core_a(core_a), .core_b(core_b)
  );

  always #5 clk = ~clk;
  always @(posedge clk) begin #3 clk_b = 1'b1; #1 wr_b = 1'b1; end
  always @(negedge clk) begin #3 clk_b = 1'b0; #1 wr_b = 1'b0; end

  // R10 ordering monitor
  realtime last_wa = -100.0, last_wb = -100.0;
  always @(posedge wr_a) last_wa = $realtime;
  always @(posedge wr_b) last_wb = $realtime;
  always @(posedge clk) begin
    #0;
    if ($realtime > last_wa && $realtime - last_wa < 2.0) ord_viol++;
  end
  always @(posedge clk_b) if ($realtime > last_wb && $realtime - last_wb < 2.0) ord_viol++;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [W-1:0] da, input logic [W-1:0] db);
    @(negedge clk);
    data_a = da;
    data_b = db;
    @(posedge clk);
    #4.5;
    if (rst) begin
      m_mode = mode_dual; m_ph = 1'b0;
      m_ha = '0; m_hb = '0; m_ca = '0; m_cb = '0;
    end else if (m_mode) begin
      m_ca = m_ha; m_ha = da;
      m_cb = m_hb; m_hb = db;
    end else begin
      if (!m_ph) begin m_ca = m_ha; m_cb = m_hb; m_ha = da; end
      else m_hb = da;
      m_ph = ~m_ph;
    end
    if (rst) begin
      check("R8 core_a", core_a, m_ca);
      check("R8 core_b", core_b, m_cb);
    end else if (m_mode) begin
      check("R3 core_a", core_a, m_ca);
      check("R4 core_b", core_b, m_cb);
    end else begin
      check("R6/R7 core_a", core_a, m_ca);
      check("R5 R7 core_b", core_b, m_cb);
    end
  endtask

  function automatic logic [W-1:0] rnd();
    return W'($urandom);
  endfunction

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R2 R8: reset in dual-bus arrangement
    rst = 1'b1; mode_dual = 1'b1;
    repeat (3) step(rnd(), rnd());
    rst = 1'b0;
    // R1 R3 R4: directed corners
    step(14'h3FFF, 14'h0000);
    step(14'h0000, 14'h3FFF);
    step(14'h2AAA, 14'h1555);
    step(14'h0001, 14'h2000);
    repeat (40) step(rnd(), rnd());
    // R8: reset mid-stream clears outputs
    rst = 1'b1; step(rnd(), rnd()); rst = 1'b0;
    step(14'h1234, 14'h0ABC);
    step(14'h3FFF, 14'h3FFF);
    // R9: mode flip without reset keeps dual behaviour
    mode_dual = 1'b0;
    repeat (12) step(rnd(), rnd());
    // R2 R8: reset into shared-bus arrangement
    rst = 1'b1; repeat (2) step(rnd(), rnd()); rst = 1'b0;
    // R6 R7: first pair lands on A then B, visible together
    step(14'h3FFF, 14'h0F0F);
    step(14'h0000, 14'h3333);
    step(14'h2222, 14'h1111);
    check("R6 first word to A", core_a, 14'h3FFF);
    check("R6 second word to B", core_b, 14'h0000);
    step(14'h1001, 14'h3FFF);
    check("R7 hold A between loads", core_a, 14'h3FFF);
    check("R7 hold B between loads", core_b, 14'h0000);
    // R5: random data_b, strobes keep toggling
    repeat (60) step(rnd(), rnd());
    // R9: flip to dual without reset, stays shared-bus
    mode_dual = 1'b1;
    repeat (13) step(rnd(), rnd());
    // R2: reset back into dual-bus arrangement
    rst = 1'b1; step(rnd(), rnd()); rst = 1'b0;
    repeat (10) step(rnd(), rnd());
    // R10: ordering of clock and write edges
    check("R10 ordering violations", W'(ord_viol), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule